// File: doc/BRIEF.md
# Fully Associative Read Cache with First-In-First-Out Replacement

This block is a small cache that sits between a processor read port and a main-memory port. Any memory block may be placed in any cache line. There is no index field. A 24-bit byte address is split into a block tag and a unit offset. The tag of every valid line is compared with the request tag in the same cycle. On a hit, the addressed byte is taken from the stored block. On a read miss, the block is fetched from memory and installed in a victim line, and the requested byte is returned.

Victim selection uses age order, not the address. Empty lines are used first. Once every line is valid, the line that has been resident the longest is replaced. A rotating pointer tracks this order. The pointer advances by one, modulo the line count, only when a miss fill completes. A write is passed through to memory. If the write hits, the stored byte is also updated. A write that misses does not allocate a line.

Four channels use valid/ready handshakes: request, response, fetch and fill. The memory write-through channel also uses valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. A sender that raises valid keeps it high, with its payload unchanged, until ready is seen. The cache holds one request at a time. Back-pressure on any channel stalls the cache without loss.

Top module: `cfa_fifo_cache`

## Requirements
- R1: While reset is low and after it is released, `req_ready` is 1 and `rsp_valid`, `fetch_valid`, `fill_ready` and `wr_valid` are 0. All lines start invalid, so the first read of any address misses.
- R2: The tag is `addr[23:2]` and the unit offset is `addr[1:0]`. Byte k of a 32-bit block occupies bits [8k+7:8k]. On a miss, `fetch_block` carries the 22-bit tag; for example, address 0xFFFFFC fetches block 0x3FFFFF and 0x16339C fetches 0x058CE7.
- R3: On a read miss, the cache issues exactly one fetch and waits for the fill. It then responds with `rsp_hit`=0 and the addressed byte of the fill data, and installs the block so that a later read of the same tag hits.
- R4: On a read hit, the cache responds with `rsp_hit`=1 and the addressed byte of the stored block, and issues no fetch.
- R5: Invalid lines are filled before any valid line is evicted. When every line is valid, a miss replaces the block that was installed earliest. Hits do not change the replacement order.
- R6: Every write produces exactly one write-through transfer, with the request address and byte. A write hit also updates the stored byte. A write miss installs nothing. The response echoes the written byte and reports hit or miss in `rsp_hit`.
- R7: At most one request is in flight. `req_ready` stays 0 from acceptance until the response is taken. While `rsp_valid` is held, `rsp_data` and `rsp_hit` stay stable. While `fetch_valid` is held, `fetch_block` stays stable.
- R8: No two valid lines ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_hit | output | 1 | 1 when the tag was resident at lookup |
| rsp_data | output | 8 | Read byte, or the echoed write byte |
| fetch_valid | output | 1 | Block fetch request to memory |
| fetch_ready | input | 1 | Memory accepts the fetch |
| fetch_block | output | 22 | Tag of the block to fetch |
| fill_valid | input | 1 | Fill data offered by memory |
| fill_ready | output | 1 | Cache waits for fill data |
| fill_data | input | 32 | Whole block, byte k in bits [8k+7:8k] |
| wr_valid | output | 1 | Write-through offered to memory |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 24 | Write-through byte address |
| wr_data | output | 8 | Write-through byte |

## Verification
The hardest state to reach is a full cache whose oldest block is evicted while a hit to that same block happens just before the eviction. A correct design keeps the hit from saving the block; a design that updates age on hits would keep it. The stimulus first uses a table of mixed reads and writes to occupy three lines. It then issues thirteen misses with distinct tags to fill every line, reads the oldest block once (a hit), and forces one more miss. It then checks that the oldest block now misses while the second-oldest still hits, and that the eviction order continues around the pointer. A final phase adds memory latency and response stalls to test that outputs stay stable under back-pressure.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

  // Controller phases of one request
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a request
    ST_LOOK,   // tags compared against the held address
    ST_FETCH,  // block fetch offered to memory
    ST_FILL,   // waiting for the block to arrive
    ST_WRITE,  // write-through offered to memory
    ST_RESP    // response offered to the requester
  } cfa_state_e;

endpackage

// File: rtl/cfa_tag_match.sv
module cfa_tag_match #(
  parameter int LINES = 16,
  parameter int TAG_W = 22,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LINES*TAG_W-1:0] tags_flat,
  input  logic [LINES-1:0]       vld,
  input  logic [TAG_W-1:0]       look_tag,
  output logic                   hit,
  output logic [IDX_W-1:0]       hit_idx
);

  logic [LINES-1:0] match_vec;

  // one comparator per line, all in parallel
  for (genvar l = 0; l < LINES; l++) begin : g_cmp
    assign match_vec[l] = vld[l] && (tags_flat[l*TAG_W +: TAG_W] == look_tag);
  end

  assign hit = |match_vec;

  // OR-based encoder: valid because at most one line matches
  for (genvar b = 0; b < IDX_W; b++) begin : g_enc
    logic [LINES-1:0] pick;
    for (genvar l = 0; l < LINES; l++) begin : g_bit
      if (((l >> b) & 1) == 1) begin : g_one
        assign pick[l] = match_vec[l];
      end else begin : g_zero
        assign pick[l] = 1'b0;
      end
    end
    assign hit_idx[b] = |pick;
  end

  // R8: a tag is resident in at most one line
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R4: encoded index points at a line that really matches
  a_r4_idx_matches: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_vec[hit_idx]);

endmodule

// File: rtl/cfa_victim_sel.sv
module cfa_victim_sel #(
  parameter int LINES = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] vld,
  input  logic             fill_done,
  output logic [IDX_W-1:0] victim_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // lowest-numbered empty line wins
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim_idx = any_free ? free_idx : ptr_q;

  // age pointer moves only when a fill lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (fill_done) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // R5: hits and idle cycles leave the age order alone
  a_r5_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_done |=> $stable(ptr_q));

  // R5: while lines are empty, the fill order and the age order agree
  a_r5_free_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> (free_idx == ptr_q));

  // R5: each completed fill moves the pointer by exactly one
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (ptr_q != $past(ptr_q)));

endmodule

// File: rtl/cfa_line_store.sv
module cfa_line_store #(
  parameter int LINES   = 16,
  parameter int TAG_W   = 22,
  parameter int UNIT_W  = 8,
  parameter int OFF_W   = 2,
  parameter int BLOCK_W = 32,
  parameter int IDX_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_en,
  input  logic [IDX_W-1:0]       fill_idx,
  input  logic [TAG_W-1:0]       fill_tag,
  input  logic [BLOCK_W-1:0]     fill_block,
  input  logic                   upd_en,
  input  logic [IDX_W-1:0]       upd_idx,
  input  logic [OFF_W-1:0]       upd_off,
  input  logic [UNIT_W-1:0]      upd_unit,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [BLOCK_W-1:0]     rd_block,
  output logic [LINES*TAG_W-1:0] tags_flat,
  output logic [LINES-1:0]       vld
);

  logic [LINES*BLOCK_W-1:0] data_flat;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic               vld_r;
    logic [TAG_W-1:0]   tag_r;
    logic [BLOCK_W-1:0] dat_r;
    logic               sel_fill;
    logic               sel_upd;

    assign sel_fill = fill_en && (fill_idx == IDX_W'(g));
    assign sel_upd  = upd_en && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
      end else if (sel_fill) begin
        vld_r <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_fill) begin
        tag_r <= fill_tag;
        dat_r <= fill_block;
      end else if (sel_upd) begin
        dat_r[upd_off*UNIT_W +: UNIT_W] <= upd_unit;
      end
    end

    assign vld[g]                         = vld_r;
    assign tags_flat[g*TAG_W +: TAG_W]     = tag_r;
    assign data_flat[g*BLOCK_W +: BLOCK_W] = dat_r;
  end

  assign rd_block = data_flat[rd_idx*BLOCK_W +: BLOCK_W];

  // R6: a byte update and a block fill never collide
  a_r6_fill_upd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && upd_en));

  // R3: a filled line is valid from the next cycle on
  a_r3_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld[$past(fill_idx)]);

endmodule

// File: rtl/cfa_fifo_cache.sv
module cfa_fifo_cache
  import cfa_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 2,
  parameter int UNIT_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [UNIT_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic                          rsp_hit,
  output logic [UNIT_W-1:0]             rsp_data,
  output logic                          fetch_valid,
  input  logic                          fetch_ready,
  output logic [ADDR_W-OFF_W-1:0]       fetch_block,
  input  logic                          fill_valid,
  output logic                          fill_ready,
  input  logic [(UNIT_W<<OFF_W)-1:0]    fill_data,
  output logic                          wr_valid,
  input  logic                          wr_ready,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [UNIT_W-1:0]             wr_data
);

  localparam int TAG_W   = ADDR_W - OFF_W;
  localparam int BLOCK_W = UNIT_W << OFF_W;
  localparam int IDX_W   = (LINES > 1) ? $clog2(LINES) : 1;

  cfa_state_e state_q;

  logic              cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [UNIT_W-1:0] cur_wdata;
  logic              hit_q;
  logic [UNIT_W-1:0] data_q;

  logic [TAG_W-1:0]       cur_tag;
  logic [OFF_W-1:0]       cur_off;
  logic [LINES*TAG_W-1:0] tags_flat;
  logic [LINES-1:0]       vld;
  logic                   hit;
  logic [IDX_W-1:0]       hit_idx;
  logic [IDX_W-1:0]       victim_idx;
  logic [BLOCK_W-1:0]     rd_block;
  logic [UNIT_W-1:0]      rd_unit;
  logic                   fill_en;
  logic                   upd_en;

  assign cur_tag = cur_addr[ADDR_W-1:OFF_W];
  assign cur_off = cur_addr[OFF_W-1:0];
  assign rd_unit = rd_block[cur_off*UNIT_W +: UNIT_W];

  assign fill_en = (state_q == ST_FILL) && fill_valid;
  assign upd_en  = (state_q == ST_LOOK) && cur_write && hit;

  cfa_tag_match #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .tags_flat (tags_flat),
    .vld       (vld),
    .look_tag  (cur_tag),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  cfa_victim_sel #(
    .LINES (LINES),
    .IDX_W (IDX_W)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld        (vld),
    .fill_done  (fill_en),
    .victim_idx (victim_idx)
  );

  cfa_line_store #(
    .LINES   (LINES),
    .TAG_W   (TAG_W),
    .UNIT_W  (UNIT_W),
    .OFF_W   (OFF_W),
    .BLOCK_W (BLOCK_W),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .fill_idx   (victim_idx),
    .fill_tag   (cur_tag),
    .fill_block (fill_data),
    .upd_en     (upd_en),
    .upd_idx    (hit_idx),
    .upd_off    (cur_off),
    .upd_unit   (cur_wdata),
    .rd_idx     (hit_idx),
    .rd_block   (rd_block),
    .tags_flat  (tags_flat),
    .vld        (vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      hit_q     <= 1'b0;
      data_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            cur_write <= req_write;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            state_q   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (cur_write) begin
            hit_q   <= hit;
            data_q  <= cur_wdata;
            state_q <= ST_WRITE;
          end else if (hit) begin
            hit_q   <= 1'b1;
            data_q  <= rd_unit;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fetch_ready) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (fill_valid) begin
            hit_q   <= 1'b0;
            data_q  <= fill_data[cur_off*UNIT_W +: UNIT_W];
            state_q <= ST_RESP;
          end
        end
        ST_WRITE: begin
          if (wr_ready) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_hit     = hit_q;
  assign rsp_data    = data_q;
  assign fetch_valid = (state_q == ST_FETCH);
  assign fetch_block = cur_tag;
  assign fill_ready  = (state_q == ST_FILL);
  assign wr_valid    = (state_q == ST_WRITE);
  assign wr_addr     = cur_addr;
  assign wr_data     = cur_wdata;

  // R7: a stalled response keeps its payload
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit));

  // R7: a stalled fetch keeps its block tag
  a_r7_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_block));

  // R7: after an accepted request no second one is taken at once
  a_r7_one_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R4: a resident tag never causes a fetch
  a_r4_no_fetch_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !hit);

  // R3: a completed fill makes the requested tag resident
  a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready |=> hit);

endmodule

// File: tb/sim_cfa_fifo_cache.sv
module sim_cfa_fifo_cache;

  localparam int LINES = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_hit;
  logic [7:0]  rsp_data;
  logic        fetch_valid;
  logic        fetch_ready;
  logic [21:0] fetch_block;
  logic        fill_valid;
  logic        fill_ready;
  logic [31:0] fill_data;
  logic        wr_valid;
  logic        wr_ready;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;

  always #4 clk = ~clk;  // 125 MHz

  cfa_fifo_cache #(.LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_block(fetch_block),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mem_lat = 0;
  int fetch_cnt = 0;
  int wr_cnt = 0;
  logic [21:0] last_blk = '0;
  logic [23:0] last_wr = '0;
  logic [7:0]  ovr [logic [23:0]];

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory image: a fixed pattern per byte unless written through
  function automatic logic [7:0] exp_unit(input logic [23:0] a);
    if (ovr.exists(a)) return ovr[a];
    return 8'(a[9:2] + 8'(37 * int'(a[1:0]) + 1));
  endfunction

  // memory model: fetch/fill and write-through channels
  initial begin
    fetch_ready = 1'b0;
    fill_valid  = 1'b0;
    fill_data   = '0;
    wr_ready    = 1'b0;
    forever begin
      @(negedge clk);
      if (fetch_valid) begin
        logic [21:0] blk;
        bit ok;
        blk = fetch_block;
        repeat (mem_lat) begin
          @(negedge clk);
          chk(fetch_valid && fetch_block == blk, "R7 fetch held", 64'(fetch_block), 64'(blk));
        end
        fetch_ready = 1'b1;
        @(negedge clk);
        fetch_ready = 1'b0;
        fetch_cnt++;
        last_blk = blk;
        for (int k = 0; k < 4; k++) fill_data[k*8 +: 8] = exp_unit({blk, 2'(k)});
        fill_valid = 1'b1;
        do begin
          ok = fill_ready;
          @(negedge clk);
        end while (!ok);
        fill_valid = 1'b0;
      end else if (wr_valid) begin
        repeat (mem_lat) @(negedge clk);
        ovr[wr_addr] = wr_data;
        last_wr = wr_addr;
        wr_cnt++;
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
      end
    end
  end

  task automatic do_req(input bit w, input logic [23:0] a, input logic [7:0] d, input int hold,
                        output bit hit, output logic [7:0] data);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(!req_ready, "R7 busy while response pending", 64'(req_ready), 64'd0);
    hit = rsp_hit;
    data = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == data && rsp_hit == hit, "R7 response held",
          64'(rsp_data), 64'(data));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic run_vec(input bit w, input logic [23:0] a, input logic [7:0] d,
                         input bit exp_hit, input int hold, input string rq);
    int f0, w0;
    bit hit;
    logic [7:0] data, exp_d;
    f0 = fetch_cnt;
    w0 = wr_cnt;
    exp_d = w ? d : exp_unit(a);
    do_req(w, a, d, hold, hit, data);
    chk(hit == exp_hit, {rq, " hit flag"}, 64'(hit), 64'(exp_hit));
    chk(data == exp_d, {rq, " data"}, 64'(data), 64'(exp_d));
    if (!w) begin
      chk(fetch_cnt - f0 == (exp_hit ? 0 : 1), exp_hit ? "R4 no fetch on hit" : "R3 one fetch on miss",
          64'(fetch_cnt - f0), exp_hit ? 64'd0 : 64'd1);
      if (!exp_hit)
        chk(last_blk == a[23:2], "R2 fetch carries tag", 64'(last_blk), 64'(a[23:2]));
    end else begin
      chk(wr_cnt - w0 == 1 && last_wr == a, "R6 write-through", 64'(last_wr), 64'(a));
      chk(fetch_cnt == f0, "R6 write does not fetch", 64'(fetch_cnt - f0), 64'd0);
    end
  endtask

  // {write, addr, wdata, expected hit}
  localparam logic [33:0] VEC [10] = '{
    {1'b0, 24'hFFFFFC, 8'h00, 1'b0},
    {1'b0, 24'hFFFFFF, 8'h00, 1'b1},
    {1'b0, 24'h16339C, 8'h00, 1'b0},
    {1'b0, 24'h16339D, 8'h00, 1'b1},
    {1'b1, 24'h16339E, 8'h5A, 1'b1},
    {1'b0, 24'h16339E, 8'h00, 1'b1},
    {1'b1, 24'h000010, 8'h3C, 1'b0},
    {1'b0, 24'h000010, 8'h00, 1'b0},
    {1'b0, 24'h000011, 8'h00, 1'b1},
    {1'b0, 24'hFFFFFD, 8'h00, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(req_ready == 1'b1, "R1 req_ready in reset", 64'(req_ready), 64'd1);
    chk(!rsp_valid && !fetch_valid && !fill_ready && !wr_valid, "R1 idle outputs in reset",
        64'({rsp_valid, fetch_valid, fill_ready, wr_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !fetch_valid && !wr_valid, "R1 idle after reset",
        64'({req_ready, rsp_valid, fetch_valid, wr_valid}), 64'h8);

    // table walk: R1 first-read miss, R2 split, R3/R4 read paths, R6 writes
    for (int i = 0; i < 10; i++)
      run_vec(VEC[i][33], VEC[i][32:9], VEC[i][8:1], VEC[i][0], 0, "R3/R4/R6 table");

    // R5: fill the remaining 13 lines with distinct tags
    for (int i = 0; i < 13; i++)
      run_vec(1'b0, {22'(22'h100 + i), 2'b01}, 8'h00, 1'b0, 0, "R5 fill empty lines");
    // R5: hit on the oldest block must not protect it
    run_vec(1'b0, 24'hFFFFFE, 8'h00, 1'b1, 0, "R5 hit before eviction");
    run_vec(1'b0, {22'h200, 2'b00}, 8'h00, 1'b0, 0, "R5 first eviction miss");
    run_vec(1'b0, 24'h16339F, 8'h00, 1'b1, 0, "R5 second-oldest kept");
    run_vec(1'b0, 24'hFFFFFC, 8'h00, 1'b0, 0, "R5 oldest was evicted");
    run_vec(1'b0, 24'h16339C, 8'h00, 1'b0, 0, "R5 next oldest evicted");
    run_vec(1'b0, 24'h000012, 8'h00, 1'b0, 0, "R5 third eviction");
    run_vec(1'b0, {22'h101, 2'b11}, 8'h00, 1'b1, 0, "R5 younger block kept");
    run_vec(1'b0, {22'h200, 2'b10}, 8'h00, 1'b1, 0, "R8 refilled block single hit");

    // R7: memory latency and response back-pressure
    mem_lat = 3;
    run_vec(1'b0, {22'h300, 2'b10}, 8'h00, 1'b0, 4, "R7 stalled miss");
    run_vec(1'b1, 24'h000013, 8'hC3, 1'b1, 2, "R6 stalled write hit");
    run_vec(1'b0, 24'h000013, 8'h00, 1'b1, 0, "R6 updated byte read back");
    run_vec(1'b0, 24'h000010, 8'h00, 1'b1, 3, "R6 earlier write-through kept");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule